// File: doc/BRIEF.md
# Receive Sample Delay Calculator

This block works out how many delay steps the receive sampling clock sits ahead of the transmit clock. The result is a programmable base delay plus an offset taken from a 4-bit tuning code. The tuning code comes from the SD host controller and is captured on an update strobe. A selectable mapping turns the code into an offset. It can add the code as it stands, ignore it, or spread the sixteen codes evenly over the number of steps in one clock cycle.

When the sum reaches or passes the step count of a cycle, an overflow policy applies. The policy can wrap the sum round the cycle, clamp it to the last step, or keep the previous delay and raise a failure bit. The block reports the resulting delay and the failure bit. It also drives a separate tap select to the delay line, which is forced to zero when bypass is on. A sticky flag tells software that a delay produced by a fresh tuning code has taken effect, and software clears it by pulsing a clear input.

Top module: `rxd_calc`

## Requirements
- R1: While reset is held, act_dly, tap_dly, fail_act and dly_updated are all 0. The base delay register resets to 6 steps, so with tuning code 0, map_sel 0 and cyc_steps 20, act_dly reads 6 soon after reset.
- R2: tune_code is captured only on a cycle with tune_upd high. The captured code shows on act_dly two clock edges after the strobe edge. A code change without a strobe leaves act_dly unchanged.
- R3: For map_sel 0 (direct), the offset equals the captured code. map_sel 3 behaves exactly like map_sel 0.
- R4: For map_sel 1 (fixed only), the offset is 0, so the delay is the base delay alone.
- R5: For map_sel 2 (stretch), the offset is floor(code × steps / 16), where steps is the effective step count.
- R6: The sum is out of range when it is at least the step count. For ovf_sel 0 (wrap), the delay is then the sum modulo the step count, even if the sum is several cycles long.
- R7: For ovf_sel 1 (clamp) and ovf_sel 3, an out-of-range sum gives a delay of steps − 1.
- R8: For ovf_sel 2 (fail), an out-of-range sum keeps act_dly at its previous value and sets fail_act. fail_act goes back to 0 as soon as the sum is in range again, and the new delay is then taken.
- R9: While bypass_en is 1, tap_dly is 0 and act_dly still shows the computed delay.
- R10: dly_updated rises three edges after the tune_upd strobe edge, which is one edge after the new delay is registered. It stays set until a cycle with upd_clr high, and a set that arrives in the same cycle wins over the clear.
- R11: The effective step count is cyc_steps limited to the range 4 to 20. Values below 4 act as 4 and values above 20 act as 20.
- R12: A cycle with base_wr high loads base_val into the base delay register. The new base shows on act_dly two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_steps | input | 5 | Delay steps in one source clock cycle (limited to 4..20) |
| base_wr | input | 1 | Load strobe for the base delay register |
| base_val | input | 5 | New base delay in steps |
| map_sel | input | 2 | Offset mapping: 0 direct, 1 fixed only, 2 stretch, 3 direct |
| ovf_sel | input | 2 | Overflow policy: 0 wrap, 1 clamp, 2 fail, 3 clamp |
| bypass_en | input | 1 | Forces the tap select to zero |
| tune_code | input | 4 | Tuning code from the host controller |
| tune_upd | input | 1 | Capture strobe for tune_code |
| upd_clr | input | 1 | Clears the updated flag |
| act_dly | output | 5 | Resulting receive delay in steps |
| fail_act | output | 1 | Fail policy is holding the delay |
| tap_dly | output | 5 | Tap select for the delay line (0 when bypassed) |
| dly_updated | output | 1 | Sticky flag: a newly captured code is in force |

## Verification
A wrong captured code or a wrong base register shows as a wrong act_dly value two edges after the stimulus. The bench samples at that edge and at the next one, so the error cannot hide behind a late transition. A broken pending pipeline shows as dly_updated rising one edge early or late, or not at all, and a bad clear priority leaves it stuck. A mistake in the wrap chain or in the fail hold appears only for sums that pass the cycle length. For that reason the stimulus includes a sum more than eleven cycles long and a fail case that follows a clamped value.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  typedef enum logic [1:0] {
    MAP_DIRECT  = 2'd0,
    MAP_FIXED   = 2'd1,
    MAP_STRETCH = 2'd2,
    MAP_ALT     = 2'd3
  } map_e;

  typedef enum logic [1:0] {
    OVF_WRAP  = 2'd0,
    OVF_CLAMP = 2'd1,
    OVF_FAIL  = 2'd2,
    OVF_RSVD  = 2'd3
  } ovf_e;

endpackage

// File: rtl/rxd_tune_capture.sv
module rxd_tune_capture #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tune_upd,
  input  logic [CODE_W-1:0] tune_code,
  input  logic              upd_clr,
  output logic [CODE_W-1:0] code_q,
  output logic              updated
);

  logic [CODE_W-1:0] code_d;
  logic              pend1_q, pend1_d;
  logic              pend2_q, pend2_d;
  logic              flag_q,  flag_d;

  always_comb begin
    code_d  = code_q;
    if (tune_upd) code_d = tune_code;
    pend1_d = tune_upd;
    pend2_d = pend1_q;
    flag_d  = flag_q;
    if (upd_clr) flag_d = 1'b0;
    if (pend2_q) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      pend1_q <= 1'b0;
      pend2_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      code_q  <= code_d;
      pend1_q <= pend1_d;
      pend2_q <= pend2_d;
      flag_q  <= flag_d;
    end
  end

  assign updated = flag_q;

  // R2
  tune_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tune_upd |=> $stable(code_q));

  // R10
  upd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend2_q |=> updated);

  // R10
  upd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_clr && !pend2_q) |=> !updated);

endmodule

// File: rtl/rxd_offset_map.sv
module rxd_offset_map
  import rxd_pkg::*;
#(
  parameter int DLY_W  = 5,
  parameter int CODE_W = 4
) (
  input  logic [1:0]        map_sel,
  input  logic [CODE_W-1:0] code,
  input  logic [DLY_W-1:0]  steps,
  output logic [DLY_W-1:0]  offset
);

  localparam int PROD_W = CODE_W + DLY_W;

  logic [PROD_W-1:0] prod;
  logic [DLY_W-1:0]  direct_off;
  logic [DLY_W-1:0]  stretch_off;
  map_e              mode;

  assign mode = map_e'(map_sel);

  generate
    if (DLY_W > CODE_W) begin : g_pad
      assign direct_off = {{(DLY_W-CODE_W){1'b0}}, code};
    end else begin : g_trunc
      assign direct_off = code[DLY_W-1:0];
    end
  endgenerate

  // code * steps / 2^CODE_W spreads the full code range over one cycle
  assign prod        = {{DLY_W{1'b0}}, code} * {{CODE_W{1'b0}}, steps};
  assign stretch_off = prod[CODE_W +: DLY_W];

  always_comb begin
    unique case (mode)
      MAP_FIXED:   offset = '0;
      MAP_STRETCH: offset = stretch_off;
      default:     offset = direct_off;
    endcase
  end

endmodule

// File: rtl/rxd_range_policy.sv
module rxd_range_policy
  import rxd_pkg::*;
#(
  parameter int DLY_W     = 5,
  parameter int MIN_STEPS = 4,
  parameter int MAX_STEPS = 20
) (
  input  logic [DLY_W:0]   sum,
  input  logic [DLY_W-1:0] steps,
  input  logic [1:0]       ovf_sel,
  input  logic [DLY_W-1:0] prev_dly,
  output logic [DLY_W-1:0] dly_nxt,
  output logic             fail_nxt
);

  // worst-case sum over the smallest cycle bounds the subtract chain
  localparam int SUM_MAX = (1 << DLY_W) - 1 + MAX_STEPS - 1;
  localparam int ITERS   = SUM_MAX / MIN_STEPS + 1;

  logic [DLY_W:0]   steps_x;
  logic [DLY_W:0]   wrap_r;
  logic             oor;
  ovf_e             pol;

  assign steps_x = {1'b0, steps};
  assign oor     = (sum >= steps_x);
  assign pol     = ovf_e'(ovf_sel);

  always_comb begin
    wrap_r = sum;
    for (int i = 0; i < ITERS; i++) begin
      if (wrap_r >= steps_x) wrap_r = wrap_r - steps_x;
    end
  end

  always_comb begin
    dly_nxt  = sum[DLY_W-1:0];
    fail_nxt = 1'b0;
    if (oor) begin
      unique case (pol)
        OVF_WRAP: dly_nxt = wrap_r[DLY_W-1:0];
        OVF_FAIL: begin
          dly_nxt  = prev_dly;
          fail_nxt = 1'b1;
        end
        default:  dly_nxt = steps - 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/rxd_calc.sv
module rxd_calc
  import rxd_pkg::*;
#(
  parameter int DLY_W      = 5,
  parameter int CODE_W     = 4,
  parameter int MIN_STEPS  = 4,
  parameter int MAX_STEPS  = 20,
  parameter int BASE_RST   = 6,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DLY_W-1:0]  cyc_steps,
  input  logic              base_wr,
  input  logic [DLY_W-1:0]  base_val,
  input  logic [1:0]        map_sel,
  input  logic [1:0]        ovf_sel,
  input  logic              bypass_en,
  input  logic [CODE_W-1:0] tune_code,
  input  logic              tune_upd,
  input  logic              upd_clr,
  output logic [DLY_W-1:0]  act_dly,
  output logic              fail_act,
  output logic [DLY_W-1:0]  tap_dly,
  output logic              dly_updated
);

  localparam logic [DLY_W-1:0] STEP_LO  = DLY_W'(MIN_STEPS);
  localparam logic [DLY_W-1:0] STEP_HI  = DLY_W'(MAX_STEPS);
  localparam logic [DLY_W-1:0] BASE_DEF = DLY_W'(BASE_RST);

  // reset: asserted asynchronously, released through a short flop chain
  logic [SYNC_DEPTH-1:0] rst_sync_q;
  logic                  rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_DEPTH-2:0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[SYNC_DEPTH-1];

  // effective step count
  logic [DLY_W-1:0] steps_eff;
  always_comb begin
    steps_eff = cyc_steps;
    if (cyc_steps < STEP_LO) steps_eff = STEP_LO;
    if (cyc_steps > STEP_HI) steps_eff = STEP_HI;
  end

  // base delay register
  logic [DLY_W-1:0] base_q, base_d;
  always_comb begin
    base_d = base_q;
    if (base_wr) base_d = base_val;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) base_q <= BASE_DEF;
    else          base_q <= base_d;
  end

  // tuning code capture and updated flag
  logic [CODE_W-1:0] code_q;

  rxd_tune_capture #(
    .CODE_W (CODE_W)
  ) u_capture (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .tune_upd  (tune_upd),
    .tune_code (tune_code),
    .upd_clr   (upd_clr),
    .code_q    (code_q),
    .updated   (dly_updated)
  );

  // offset mapping
  logic [DLY_W-1:0] offset;

  rxd_offset_map #(
    .DLY_W  (DLY_W),
    .CODE_W (CODE_W)
  ) u_map (
    .map_sel (map_sel),
    .code    (code_q),
    .steps   (steps_eff),
    .offset  (offset)
  );

  // range policy
  logic [DLY_W:0]   sum;
  logic [DLY_W-1:0] act_q, act_d;
  logic             fail_q, fail_d;
  logic [DLY_W-1:0] tap_q, tap_d;

  assign sum = {1'b0, base_q} + {1'b0, offset};

  rxd_range_policy #(
    .DLY_W     (DLY_W),
    .MIN_STEPS (MIN_STEPS),
    .MAX_STEPS (MAX_STEPS)
  ) u_policy (
    .sum      (sum),
    .steps    (steps_eff),
    .ovf_sel  (ovf_sel),
    .prev_dly (act_q),
    .dly_nxt  (act_d),
    .fail_nxt (fail_d)
  );

  always_comb begin
    tap_d = act_d;
    if (bypass_en) tap_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      act_q  <= '0;
      fail_q <= 1'b0;
      tap_q  <= '0;
    end else begin
      act_q  <= act_d;
      fail_q <= fail_d;
      tap_q  <= tap_d;
    end
  end

  assign act_dly  = act_q;
  assign fail_act = fail_q;
  assign tap_dly  = tap_q;

  // R6 R7
  in_range_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !fail_d |=> (act_q < $past(steps_eff)));

  // R8
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    fail_d |=> (fail_act && act_q == $past(act_q)));

  // R9
  bypass_tap_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    bypass_en |=> (tap_dly == '0));

  // R5
  stretch_off_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (map_sel == 2'd2) |-> (offset < steps_eff));

endmodule

// File: tb/rxd_calc_tb_top.sv
`timescale 1ns/1ps
module rxd_calc_tb_top;

  logic       clk;
  logic       rst_n;
  logic [4:0] cyc_steps;
  logic       base_wr;
  logic [4:0] base_val;
  logic [1:0] map_sel;
  logic [1:0] ovf_sel;
  logic       bypass_en;
  logic [3:0] tune_code;
  logic       tune_upd;
  logic       upd_clr;
  logic [4:0] act_dly;
  logic       fail_act;
  logic [4:0] tap_dly;
  logic       dly_updated;

  rxd_calc dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_steps   (cyc_steps),
    .base_wr     (base_wr),
    .base_val    (base_val),
    .map_sel     (map_sel),
    .ovf_sel     (ovf_sel),
    .bypass_en   (bypass_en),
    .tune_code   (tune_code),
    .tune_upd    (tune_upd),
    .upd_clr     (upd_clr),
    .act_dly     (act_dly),
    .fail_act    (fail_act),
    .tap_dly     (tap_dly),
    .dly_updated (dly_updated)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    int         cyc;
    logic [4:0] dly;
    logic       fail;
    logic [4:0] tap;
    logic       upd;
    string      rq;
  } exp_t;

  exp_t sb[$];
  int   cyc;
  int   n_chk;
  int   n_err;
  bit   done;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int c, input logic [4:0] d, input logic f,
                      input logic [4:0] t, input logic u, input string rq);
    exp_t e;
    e.cyc = c; e.dly = d; e.fail = f; e.tap = t; e.upd = u; e.rq = rq;
    sb.push_back(e);
  endtask

  // monitor: compare outputs when an expected item falls due
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].cyc == cyc) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (act_dly !== e.dly || fail_act !== e.fail ||
          tap_dly !== e.tap || dly_updated !== e.upd) begin
        n_err++;
        $display("FAIL %s: act/fail/tap/upd got %0d/%0b/%0d/%0b expected %0d/%0b/%0d/%0b",
                 e.rq, act_dly, fail_act, tap_dly, dly_updated,
                 e.dly, e.fail, e.tap, e.upd);
      end
    end
  end

  // driver: apply one setting, optionally strobe the code, push expectations
  task automatic run(input logic [4:0] st, input logic bw, input logic [4:0] bv,
                     input logic [1:0] mp, input logic [1:0] ov, input logic by,
                     input logic [3:0] cd, input logic stb,
                     input logic [4:0] e_dly, input logic e_fail, input string rq);
    int c;
    logic [4:0] e_tap;
    @(negedge clk);
    c = cyc;
    cyc_steps = st; base_wr = bw; base_val = bv; map_sel = mp;
    ovf_sel = ov; bypass_en = by; tune_code = cd; tune_upd = stb;
    e_tap = by ? 5'd0 : e_dly;
    push(c + 2, e_dly, e_fail, e_tap, 1'b0, rq);
    push(c + 3, e_dly, e_fail, e_tap, stb, stb ? {rq, " R10 set"} : rq);
    if (stb) push(c + 4, e_dly, e_fail, e_tap, 1'b0, {rq, " R10 clear"});
    @(negedge clk);
    tune_upd = 1'b0; base_wr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    if (stb) upd_clr = 1'b1;
    @(negedge clk);
    upd_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    cyc = 0; n_chk = 0; n_err = 0; done = 0;
    rst_n = 1'b0;
    cyc_steps = 5'd20; base_wr = 1'b0; base_val = '0; map_sel = 2'd0;
    ovf_sel = 2'd1; bypass_en = 1'b0; tune_code = 4'd0; tune_upd = 1'b0;
    upd_clr = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    n_chk++;
    if (act_dly !== 0 || fail_act !== 0 || tap_dly !== 0 || dly_updated !== 0) begin
      n_err++;
      $display("FAIL R1 reset: act/fail/tap/upd got %0d/%0b/%0d/%0b expected 0/0/0/0",
               act_dly, fail_act, tap_dly, dly_updated);
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    //   steps  bw  bv     map   ovf   byp  code  stb  exp  fail
    run(5'd20, 0, 5'd0,  2'd0, 2'd1, 0, 4'd0,  1, 5'd6,  0, "R1 default base");
    run(5'd20, 0, 5'd0,  2'd0, 2'd1, 0, 4'd5,  1, 5'd11, 0, "R3 direct");
    run(5'd12, 1, 5'd1,  2'd2, 2'd1, 0, 4'd8,  1, 5'd7,  0, "R5 stretch mid");
    run(5'd10, 1, 5'd0,  2'd2, 2'd1, 0, 4'd15, 1, 5'd9,  0, "R5 stretch top R12");
    run(5'd8,  1, 5'd6,  2'd0, 2'd0, 0, 4'd7,  1, 5'd5,  0, "R6 wrap");
    run(5'd4,  1, 5'd31, 2'd0, 2'd0, 0, 4'd15, 1, 5'd2,  0, "R6 wrap deep");
    run(5'd16, 1, 5'd10, 2'd0, 2'd1, 0, 4'd9,  1, 5'd15, 0, "R7 clamp");
    run(5'd16, 0, 5'd0,  2'd0, 2'd2, 0, 4'd9,  1, 5'd15, 1, "R8 fail hold");
    run(5'd16, 0, 5'd0,  2'd0, 2'd2, 0, 4'd0,  1, 5'd10, 0, "R8 fail recover");
    run(5'd16, 0, 5'd0,  2'd0, 2'd3, 0, 4'd9,  1, 5'd15, 0, "R7 policy 3 clamps");
    run(5'd20, 1, 5'd7,  2'd1, 2'd1, 0, 4'd15, 1, 5'd7,  0, "R4 fixed only");
    run(5'd20, 0, 5'd0,  2'd3, 2'd1, 0, 4'd3,  1, 5'd10, 0, "R3 map 3 direct");
    run(5'd20, 0, 5'd0,  2'd3, 2'd1, 1, 4'd3,  0, 5'd10, 0, "R9 bypass");
    run(5'd20, 0, 5'd0,  2'd3, 2'd1, 0, 4'd9,  0, 5'd10, 0, "R2 no strobe");
    run(5'd0,  1, 5'd3,  2'd0, 2'd1, 0, 4'd2,  1, 5'd3,  0, "R11 steps low");
    run(5'd31, 1, 5'd6,  2'd0, 2'd1, 0, 4'd15, 1, 5'd19, 0, "R11 steps high");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      n_err++;
      $display("FAIL R2 scoreboard: got %0d pending items expected 0", sb.size());
    end
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_err++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule